// File: doc/BRIEF.md
# Code-Hopping Word Pulse Serializer

This block takes one 67-bit remote-keyless-entry code word, handed over as separate fields, and drives it onto a single on-air data line as a timed pulse train. A word goes out in this order: an optional wake-up burst with its dead time, then a preamble, a sync segment, a header, the 67 data bits and a guard time. All timing is a whole number of base elements (TE).

Two bit encodings are supported. One is pulse-width coding with a selectable 3-TE or 6-TE bit. The other is transition-direction coding with a 2-TE bit. Option bits select the TE length and the guard length. An infrared option gates every high level with a carrier derived from the same clock. The block adds a 2-bit serial CRC over the first 65 bits itself and appends it.

The block latches all fields and options on a load strobe. While a word is in flight it ignores any further load. It gives a one-cycle done pulse when the guard time ends. Choosing what to send is left to the surrounding logic.

Top module: `hop_word_serializer`

## Requirements
- R1: After reset and whenever no word is in flight, `tx_o` and `done_o` are 0.
- R2: The TE length in clocks, with CH = parameter `CAR_HALF`, is as follows.
  - Pulse-width mode (`mod_i`=0) with `txwak_i`=0: 32·CH when `bsel_i`=0, 16·CH when `bsel_i`=1.
  - Pulse-width mode with `txwak_i`=1: 16·CH when `bsel_i`=0, 8·CH when `bsel_i`=1.
  - Transition mode (`mod_i`=1): 32·CH when `bsel_i`=0, 16·CH when `bsel_i`=1.
  - The preamble is 28 TE long and is high on even TE indices (0, 2, …) and low on odd ones.
- R3: After the preamble come a 10-TE sync segment and then a 10-TE header that is low throughout. The sync segment is high throughout when `spm_i`=0. When `spm_i`=1 it is high on even TE indices and low on odd ones.
- R4: In pulse-width mode, each bit is sent as follows.
  - With `txwak_i`=0 the bit is 3 TE: high, then NOT d, then low.
  - With `txwak_i`=1 the bit is 6 TE: high, then NOT d, then four TE low.
- R5: In transition mode each bit is 2 TE: d, then NOT d. A 1 therefore falls at mid-bit and a 0 rises at mid-bit.
- R6: Data bits are sent in index order 0 to 66.
  - Bits 0–31 are `enc_i[0..31]`.
  - With `xser_i`=0, bits 32–59 are `ser_i[0..27]` and bits 60–63 are `func_i[0..3]`.
  - With `xser_i`=1, bits 32–63 are `ser_i[0..31]`.
  - Bit 64 is `vlow_i`.
- R7: The CRC pair (c1,c0) starts at 0. For each bit d of bits 0–64 in order, the new c1 is c0^d and the new c0 is (c0^d)^c1. Bit 65 carries the final c0 and bit 66 the final c1.
- R8: The guard time is low throughout its length. It is 18 TE (`bsel_i`=0) or 34 TE (`bsel_i`=1) in pulse-width mode, and 114 TE or 226 TE in transition mode.
- R9: When `mod_i`=1, `txwak_i`=1 and `first_i`=1, the preamble is preceded by a 250-TE wake-up burst and then 258 TE low. The burst is high on TE indices that are multiples of 3. Any other option combination sends no wake-up.
- R10: With `ind_i`=1 every high level is ANDed with a carrier of period 2·CH clocks. The carrier restarts high at the first clock of each TE. With `ind_i`=0 there is no gating.
- R11: Fields and options are latched on the edge where `load_i` is seen while idle. The first TE starts in the next cycle. A `load_i` during a word has no effect on that word and starts no further word.
- R12: `done_o` is high for exactly one cycle, the cycle after the last guard clock. A load in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Start a word with the fields below |
| enc_i | input | 32 | Encrypted portion |
| ser_i | input | 32 | Serial number |
| func_i | input | 4 | Function (button) code |
| vlow_i | input | 1 | Low-battery flag |
| xser_i | input | 1 | 1: send 32 serial bits instead of 28 plus function |
| mod_i | input | 1 | 0: pulse-width coding, 1: transition coding |
| bsel_i | input | 1 | Faster TE select |
| txwak_i | input | 1 | Pulse-width: 6-TE bit; transition: wake-up enable |
| spm_i | input | 1 | Modulate the sync segment |
| ind_i | input | 1 | Infrared carrier gating |
| first_i | input | 1 | This word opens a transmission |
| tx_o | output | 1 | On-air data line |
| done_o | output | 1 | One-cycle end-of-word pulse |

## Verification
The first TE of a word appears at `tx_o` one cycle after the edge that samples `load_i`. `done_o` rises one cycle after the last guard clock. A load presented in that done cycle starts the next word in the following cycle. The bench builds the whole expected waveform from the requirements as a per-clock queue when it issues an accepted load. It compares `tx_o` and `done_o` one nanosecond after every rising edge, so each value is checked in exactly the cycle it is due. Loads sent while the model still holds queued cycles push nothing, which makes any reaction to an ignored load visible as a mismatch.

// File: rtl/hop_word_serializer.sv
module hop_word_serializer #(
  parameter int CAR_HALF = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] enc_i,
  input  logic [31:0] ser_i,
  input  logic [3:0]  func_i,
  input  logic        vlow_i,
  input  logic        xser_i,
  input  logic        mod_i,
  input  logic        bsel_i,
  input  logic        txwak_i,
  input  logic        spm_i,
  input  logic        ind_i,
  input  logic        first_i,
  output logic        tx_o,
  output logic        done_o
);
  localparam int TE_LONG  = 32 * CAR_HALF;
  localparam int TE_MID   = 16 * CAR_HALF;
  localparam int TE_SHORT = 8 * CAR_HALF;
  localparam int TW = $clog2(TE_LONG);
  localparam int CW = (CAR_HALF > 1) ? $clog2(CAR_HALF) : 1;
  localparam int NPAY = 65;

  localparam logic [2:0] P_IDLE = 3'd0, P_WAKE = 3'd1, P_DEAD = 3'd2, P_PRE = 3'd3,
                         P_SYNC = 3'd4, P_HDR = 3'd5, P_DATA = 3'd6, P_GRD = 3'd7;

  logic [2:0]      phase;
  logic [NPAY-1:0] pay;
  logic            md_q, bs_q, tw_q, sp_q, ir_q;
  logic [TW-1:0]   te_cnt;
  logic [8:0]      seg_cnt;
  logic [6:0]      bit_idx;
  logic [2:0]      slot;
  logic [1:0]      crc;
  logic [CW-1:0]   car_cnt;
  logic            car_ph;
  logic            done_q;

  logic [TW:0] te_len;
  logic [2:0]  bit_len;
  logic [8:0]  seg_len;
  logic        te_last, d_bit, crc_fb, level;

  always_comb begin
    if (!md_q && tw_q) te_len = bs_q ? (TW+1)'(TE_SHORT) : (TW+1)'(TE_MID);
    else               te_len = bs_q ? (TW+1)'(TE_MID)   : (TW+1)'(TE_LONG);
  end

  assign te_last = ({1'b0, te_cnt} == te_len - 1'b1);
  assign bit_len = md_q ? 3'd2 : (tw_q ? 3'd6 : 3'd3);

  always_comb begin
    case (phase)
      P_WAKE:  seg_len = 9'd250;
      P_DEAD:  seg_len = 9'd258;
      P_PRE:   seg_len = 9'd28;
      P_SYNC:  seg_len = 9'd10;
      P_HDR:   seg_len = 9'd10;
      P_GRD:   seg_len = md_q ? (bs_q ? 9'd226 : 9'd114) : (bs_q ? 9'd34 : 9'd18);
      default: seg_len = 9'd1;
    endcase
  end

  assign d_bit  = (bit_idx < 7'd65) ? pay[bit_idx] : ((bit_idx == 7'd65) ? crc[0] : crc[1]);
  assign crc_fb = crc[0] ^ d_bit;

  always_comb begin
    case (phase)
      P_WAKE:  level = ((seg_cnt % 9'd3) == 9'd0);
      P_PRE:   level = ~seg_cnt[0];
      P_SYNC:  level = sp_q ? ~seg_cnt[0] : 1'b1;
      P_DATA: begin
        if (md_q)              level = (slot == 3'd0) ? d_bit : ~d_bit;
        else if (slot == 3'd0) level = 1'b1;
        else if (slot == 3'd1) level = ~d_bit;
        else                   level = 1'b0;
      end
      default: level = 1'b0;
    endcase
  end

  assign tx_o   = level & (ir_q ? car_ph : 1'b1);
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      pay     <= '0;
      md_q    <= 1'b0;
      bs_q    <= 1'b0;
      tw_q    <= 1'b0;
      sp_q    <= 1'b0;
      ir_q    <= 1'b0;
      te_cnt  <= '0;
      seg_cnt <= '0;
      bit_idx <= '0;
      slot    <= '0;
      crc     <= '0;
      car_cnt <= '0;
      car_ph  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase == P_IDLE) begin
        if (load_i) begin
          pay     <= xser_i ? {vlow_i, ser_i, enc_i} : {vlow_i, func_i, ser_i[27:0], enc_i};
          md_q    <= mod_i;
          bs_q    <= bsel_i;
          tw_q    <= txwak_i;
          sp_q    <= spm_i;
          ir_q    <= ind_i;
          phase   <= (mod_i && txwak_i && first_i) ? P_WAKE : P_PRE;
          te_cnt  <= '0;
          seg_cnt <= '0;
          bit_idx <= '0;
          slot    <= '0;
          crc     <= '0;
          car_cnt <= '0;
          car_ph  <= 1'b1;
        end
      end else begin
        if (te_last) begin
          car_cnt <= '0;
          car_ph  <= 1'b1;
        end else if (car_cnt == CW'(CAR_HALF - 1)) begin
          car_cnt <= '0;
          car_ph  <= ~car_ph;
        end else begin
          car_cnt <= car_cnt + 1'b1;
        end

        if (!te_last) begin
          te_cnt <= te_cnt + 1'b1;
        end else begin
          te_cnt <= '0;
          if (phase == P_DATA) begin
            if (slot == bit_len - 1'b1) begin
              slot <= '0;
              if (bit_idx <= 7'd64) crc <= {crc_fb, crc_fb ^ crc[1]};
              if (bit_idx == 7'd66) begin
                phase   <= P_GRD;
                seg_cnt <= '0;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end else begin
              slot <= slot + 1'b1;
            end
          end else if (seg_cnt == seg_len - 1'b1) begin
            seg_cnt <= '0;
            case (phase)
              P_WAKE: phase <= P_DEAD;
              P_DEAD: phase <= P_PRE;
              P_PRE:  phase <= P_SYNC;
              P_SYNC: phase <= P_HDR;
              P_HDR: begin
                phase   <= P_DATA;
                bit_idx <= '0;
                slot    <= '0;
              end
              default: begin
                phase  <= P_IDLE;
                done_q <= 1'b1;
              end
            endcase
          end else begin
            seg_cnt <= seg_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hop_word_serializer_chk.sv
module hop_word_serializer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_i,
  input logic        tx_o,
  input logic        done_o,
  input logic [2:0]  phase,
  input logic [64:0] pay,
  input logic [6:0]  bit_idx,
  input logic [1:0]  crc
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> !tx_o);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phase == 3'd0 || phase == 3'd1 || phase == 3'd3) == (phase != 3'd7));

  assert_busy_load_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd0 && load_i) |=> $stable(pay));

  assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd6 && bit_idx == 7'd66) |-> $stable(crc));

  assert_bit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= 7'd66);
endmodule

bind hop_word_serializer hop_word_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .tx_o(tx_o), .done_o(done_o),
  .phase(phase), .pay(pay), .bit_idx(bit_idx), .crc(crc)
);

// File: tb/hop_word_serializer_bench.sv
`timescale 1ns/1ps
module hop_word_serializer_bench;
  localparam int CH = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [31:0] enc_i = '0, ser_i = '0;
  logic [3:0] func_i = '0;
  logic vlow_i = 0, xser_i = 0, mod_i = 0, bsel_i = 0, txwak_i = 0, spm_i = 0, ind_i = 0, first_i = 0;
  logic tx_o, done_o;

  always #2 clk = ~clk;

  hop_word_serializer #(.CAR_HALF(CH)) u_hop_word_serializer (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .enc_i(enc_i), .ser_i(ser_i),
    .func_i(func_i), .vlow_i(vlow_i), .xser_i(xser_i), .mod_i(mod_i), .bsel_i(bsel_i),
    .txwak_i(txwak_i), .spm_i(spm_i), .ind_i(ind_i), .first_i(first_i),
    .tx_o(tx_o), .done_o(done_o)
  );

  int checks = 0, failures = 0, done_cnt = 0;
  bit run = 0;
  bit [1:0] eq[$];
  int tq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference waveform: R2 TE, R3 framing, R4/R5 encodings, R6 order, R7 CRC,
  // R8 guard, R9 wake-up, R10 carrier, R12 done cycle.
  task automatic push_word(input [31:0] enc, input [31:0] ser, input [3:0] fn,
                           input bit vl, xs, md, bs, tw, sp, ir, fst);
    bit lv[$];
    int tg[$];
    bit d[67];
    bit c0, c1, t;
    int te, guard;
    te = md ? (bs ? 16 : 32) * CH : (tw ? (bs ? 8 : 16) * CH : (bs ? 16 : 32) * CH);
    guard = md ? (bs ? 226 : 114) : (bs ? 34 : 18);
    if (md && tw && fst) begin
      for (int i = 0; i < 250; i++) begin lv.push_back(i % 3 == 0); tg.push_back(9); end
      for (int i = 0; i < 258; i++) begin lv.push_back(1'b0); tg.push_back(9); end
    end
    for (int i = 0; i < 28; i++) begin lv.push_back(i % 2 == 0); tg.push_back(2); end
    for (int i = 0; i < 10; i++) begin lv.push_back(sp ? (i % 2 == 0) : 1'b1); tg.push_back(3); end
    for (int i = 0; i < 10; i++) begin lv.push_back(1'b0); tg.push_back(3); end
    for (int i = 0; i < 32; i++) d[i] = enc[i];
    if (xs) for (int i = 0; i < 32; i++) d[32+i] = ser[i];
    else begin
      for (int i = 0; i < 28; i++) d[32+i] = ser[i];
      for (int i = 0; i < 4; i++) d[60+i] = fn[i];
    end
    d[64] = vl;
    c0 = 0; c1 = 0;
    for (int i = 0; i <= 64; i++) begin
      t = c0 ^ d[i];
      c0 = t ^ c1;
      c1 = t;
    end
    d[65] = c0; d[66] = c1;
    for (int n = 0; n < 67; n++) begin
      int tag;
      tag = (n < 32) ? (md ? 5 : 4) : ((n < 65) ? 6 : 7);
      if (md) begin
        lv.push_back(d[n]); lv.push_back(~d[n]); tg.push_back(tag); tg.push_back(tag);
      end else begin
        lv.push_back(1'b1); lv.push_back(~d[n]); lv.push_back(1'b0);
        tg.push_back(tag); tg.push_back(tag); tg.push_back(tag);
        if (tw) for (int k = 0; k < 3; k++) begin lv.push_back(1'b0); tg.push_back(tag); end
      end
    end
    for (int i = 0; i < guard; i++) begin lv.push_back(1'b0); tg.push_back(8); end
    for (int j = 0; j < lv.size(); j++)
      for (int c = 0; c < te; c++) begin
        eq.push_back({1'b0, lv[j] & (ir ? ((c / CH) % 2 == 0) : 1'b1)});
        tq.push_back(ir ? 10 : tg[j]);
      end
    eq.push_back(2'b10);
    tq.push_back(12);
  endtask

  // Caller stands at a negedge. R11: pushes only if the model is idle.
  task automatic load_word(input [31:0] enc, input [31:0] ser, input [3:0] fn,
                           input bit vl, xs, md, bs, tw, sp, ir, fst);
    enc_i = enc; ser_i = ser; func_i = fn; vlow_i = vl; xser_i = xs; mod_i = md;
    bsel_i = bs; txwak_i = tw; spm_i = sp; ind_i = ir; first_i = fst;
    load_i = 1'b1;
    if (eq.size() == 0) push_word(enc, ser, fn, vl, xs, md, bs, tw, sp, ir, fst);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (eq.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (run) begin
      bit [1:0] e;
      int tg;
      if (eq.size() > 0) begin e = eq.pop_front(); tg = tq.pop_front(); end
      else begin e = 2'b00; tg = 1; end
      checks++;
      if ({done_o, tx_o} !== e) begin
        failures++;
        $display("FAIL R%0d t=%0t actual done/tx=%b%b expected=%b%b", tg, $time, done_o, tx_o, e[1], e[0]);
      end
      if (done_o === 1'b1) done_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int dc;
    repeat (3) @(negedge clk);
    chk(tx_o == 1'b0 && done_o == 1'b0, "R1 reset outputs", {done_o, tx_o}, 0);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (5) @(negedge clk);

    // R4 R6 R7: pulse-width 3-TE bit, 28-bit serial + function
    dc = done_cnt;
    load_word(32'hA5C3_0F96, 32'h0BAD_F00D, 4'b1001, 1, 0, 0, 1, 0, 0, 0, 0);
    wait_idle();
    chk(done_cnt == dc + 1, "R12 one done per word", done_cnt - dc, 1);

    // R12 back-to-back in done cycle; R3 sync modulated; R4 6-TE bit; R6 extended serial
    dc = done_cnt;
    load_word(32'h1234_5678, 32'hFEDC_BA98, 4'b0011, 0, 1, 0, 1, 1, 1, 0, 1);
    repeat (300) @(negedge clk);
    // R11: this load must be ignored
    load_word(32'hFFFF_FFFF, 32'h0, 4'hF, 1, 0, 1, 0, 0, 0, 1, 1);
    wait_idle();
    chk(done_cnt == dc + 1, "R11 busy load ignored", done_cnt - dc, 1);

    // R9 wake-up in transition mode, R5 encoding, R8 long guard
    dc = done_cnt;
    load_word(32'h8000_0001, 32'h0123_4567, 4'b0100, 0, 0, 1, 1, 1, 0, 0, 1);
    wait_idle();
    chk(done_cnt == dc + 1, "R9 wake-up word done", done_cnt - dc, 1);

    // R5 R8 transition mode slow TE, no wake-up
    dc = done_cnt;
    load_word(32'h0000_0000, 32'hFFFF_FFFF, 4'b1111, 1, 1, 1, 0, 0, 1, 0, 1);
    wait_idle();
    chk(done_cnt == dc + 1, "R5 transition word done", done_cnt - dc, 1);

    // R10 infrared carrier gating
    dc = done_cnt;
    load_word(32'hDEAD_BEEF, 32'h0765_4321, 4'b0110, 0, 0, 0, 1, 1, 1, 1, 0);
    wait_idle();
    chk(done_cnt == dc + 1, "R10 infrared word done", done_cnt - dc, 1);

    // R9 negative: pulse-width with txwak=1, first=1 has no wake-up; R10 ir in transition
    dc = done_cnt;
    load_word(32'h5555_AAAA, 32'h0A0A_0A0A, 4'b1100, 1, 0, 0, 0, 1, 0, 0, 1);
    wait_idle();
    chk(done_cnt == dc + 1, "R9 no wake-up in pulse-width", done_cnt - dc, 1);

    dc = done_cnt;
    load_word(32'h0F0F_F0F0, 32'h0333_CCCC, 4'b0001, 1, 0, 1, 1, 0, 0, 1, 0);
    wait_idle();
    chk(done_cnt == dc + 1, "R10 transition infrared", done_cnt - dc, 1);

    // R2 slowest pulse-width TE
    dc = done_cnt;
    load_word(32'h7E57_0001, 32'h0000_0001, 4'b0010, 0, 0, 0, 0, 0, 0, 0, 0);
    wait_idle();
    chk(done_cnt == dc + 1, "R2 slow TE word", done_cnt - dc, 1);

    repeat (20) @(negedge clk);
    chk(tx_o == 1'b0 && done_o == 1'b0, "R1 idle after words", {done_o, tx_o}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule